// File: doc/BRIEF.md
# Nibble-Serial 8-Bit Arithmetic Logic Unit

This block performs byte-wide arithmetic and logic with a single 4-bit slice that runs twice per operation. In the first half-phase it handles the low nibbles and keeps the slice's low result and carry-out. In the second half-phase it handles the high nibbles, using the kept carry where the operation needs one. The block then presents the full byte result with a carry flag, an overflow flag and a one-cycle completion pulse.

An instruction sequencer raises `start` for one cycle with the operands, the incoming carry and a 3-bit operation code. The block captures these values at that edge. Each half-phase lasts `PHASE_LEN` clock cycles, and the half-result is stored at the end of the last of those cycles. The outputs stay stable until the next operation completes. Register access and instruction decode belong to the surrounding datapath.

Top module: `nibser_alu`

## Requirements
- R1: While `rst_n` is low and after its release, `result`, `c_flag`, `v_flag` and `done` are all 0.
- R2: When `start` is accepted at a clock edge, `done` is high for exactly one cycle. That cycle follows the 2*PHASE_LEN-th edge after acceptance (the 4th edge with defaults). `result`, `c_flag` and `v_flag` are valid in that same cycle.
- R3: A `start` that arrives while an operation is in progress is ignored. The captured operands are not replaced, and no extra `done` pulse follows.
- R4: Code 0 (add) gives `result` = (a+b) mod 256 and `c_flag` = bit 8 of a+b. The carry input is ignored.
- R5: Code 1 (add with carry) gives `result` = (a+b+cin) mod 256 and `c_flag` = bit 8 of that sum.
- R6: Code 2 (subtract) gives `result` = (a+~b+1) mod 256 and `c_flag` = bit 8 of that sum. A carry of 1 means no borrow. The carry input is ignored.
- R7: Code 3 (subtract with carry) gives `result` = (a+~b+cin) mod 256 and `c_flag` = bit 8 of that sum.
- R8: For codes 0 to 3, `v_flag` is the signed two's-complement overflow of the whole 8-bit operation.
- R9: Code 4 gives `result` = ~(a&b), `c_flag` = cin and `v_flag` = 0.
- R10: Code 5 rotates `a` right through the carry: `result` = {cin, a[7:1]}, `c_flag` = a[0] and `v_flag` = 0.
- R11: Codes 6 and 7 pass `a` through: `result` = a, `c_flag` = cin and `v_flag` = 0.
- R12: `result`, `c_flag` and `v_flag` change only in a cycle where `done` is high.
- R13: A `start` raised in the same cycle as `done` is accepted, which allows back-to-back operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Operation request strobe |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| cin | input | 1 | Incoming carry |
| op | input | 3 | Operation code |
| result | output | 8 | Byte result |
| c_flag | output | 1 | Carry flag |
| v_flag | output | 1 | Signed overflow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench checks that the kept low carry reaches the high step. It uses operands such as 0x0F+0x01 and 0xFF+0x01: a design that fed the high nibble the original carry would return a high nibble that is off by one. Overflow is checked against whole-byte signed rules at 0x7F/0x80 boundaries in both directions. A design that took V from the low nibble, or kept V set for logic codes, would show a wrong flag there.

The rotate case needs a[4] to move into bit 3 and a[0] to come out as the carry. A design that recirculated the wrong bit produces a corrupted middle bit or the wrong carry. Further tests check the exact `done` cycle, back-to-back starts, and a mid-operation `start` carrying different operands. A design that re-captured operands while busy would report the second operation's value, or pulse `done` twice.

// File: rtl/nibser_alu_pkg.sv
// Shared operation encoding for the nibble-serial ALU.
// Assumes a 3-bit code; codes 6 and 7 both pass the first operand through.
package nibser_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBC  = 3'd3,
        OP_NAND = 3'd4,
        OP_RRC  = 3'd5,
        OP_PASS = 3'd6,
        OP_PAS2 = 3'd7
    } alu_op_e;

    // True for the four carry-propagating codes
    function automatic logic is_arith(input logic [2:0] code);
        return code[2] == 1'b0;
    endfunction

    // True for the two codes that subtract via an inverted second operand
    function automatic logic is_sub(input logic [2:0] code);
        return (code == OP_SUB) || (code == OP_SBC);
    endfunction
endpackage

// File: rtl/nibser_slice.sv
// One NIB_W-bit ALU slice, purely combinational.
// Input bus packs {b, a, carry, op}; output bus packs {data, overflow, carry}.
// Assumes the caller picks the carry-in appropriate to each step.
module nibser_slice #(
    parameter int NIB_W = 4,
    localparam int IN_W  = 2 * NIB_W + 4,
    localparam int OUT_W = NIB_W + 2
) (
    input  logic [IN_W-1:0]  in_bus,
    output logic [OUT_W-1:0] out_bus
);
    import nibser_alu_pkg::*;

    logic [NIB_W-1:0] op_a, op_b, b_eff, d;
    logic [2:0]       code;
    logic             ci, co, vo;
    logic [NIB_W:0]   sum;

    // Unpack the slice input bus
    always_comb begin
        op_b = in_bus[IN_W-1 -: NIB_W];
        op_a = in_bus[NIB_W+3 -: NIB_W];
        ci   = in_bus[3];
        code = in_bus[2:0];
    end

    // Adder path shared by the four arithmetic codes
    always_comb begin
        b_eff = is_sub(code) ? ~op_b : op_b;
        sum   = {1'b0, op_a} + {1'b0, b_eff} + {{NIB_W{1'b0}}, ci};
    end

    // Select the slice result by operation code
    always_comb begin
        d  = sum[NIB_W-1:0];
        co = sum[NIB_W];
        vo = 1'b0;
        if (is_arith(code)) begin
            vo = (op_a[NIB_W-1] == b_eff[NIB_W-1]) && (d[NIB_W-1] != op_a[NIB_W-1]);
        end else if (code == OP_NAND) begin
            d  = ~(op_a & op_b);
            co = ci;
        end else if (code == OP_RRC) begin
            d  = {ci, op_a[NIB_W-1:1]};
            co = op_a[0];
        end else begin
            d  = op_a;
            co = ci;
        end
    end

    // Pack the slice output bus
    always_comb out_bus = {d, vo, co};
endmodule

// File: rtl/nibser_seq.sv
// Two half-phase sequencer. Each half-phase lasts PHASE_LEN cycles;
// the store strobe is raised in the last cycle of each half-phase.
// Assumes start is only acted on while idle.
module nibser_seq #(
    parameter int PHASE_LEN = 2,
    localparam int CNT_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic accept,
    output logic sel_hi,
    output logic store_lo,
    output logic store_hi
);
    typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} seq_state_e;

    seq_state_e       state;
    logic [CNT_W-1:0] ph_cnt;
    logic             last;

    // Decode phase position and strobes
    always_comb begin
        last     = (ph_cnt == CNT_W'(PHASE_LEN - 1));
        idle     = (state == S_IDLE);
        accept   = idle && start;
        sel_hi   = (state == S_HI);
        store_lo = (state == S_LO) && last;
        store_hi = (state == S_HI) && last;
    end

    // Advance through idle, low half-phase and high half-phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            ph_cnt <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state  <= S_LO;
                    ph_cnt <= '0;
                end
                S_LO: if (last) begin
                    state  <= S_HI;
                    ph_cnt <= '0;
                end else begin
                    ph_cnt <= ph_cnt + 1'b1;
                end
                S_HI: if (last) begin
                    state  <= S_IDLE;
                    ph_cnt <= '0;
                end else begin
                    ph_cnt <= ph_cnt + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nibser_oper.sv
// Operand capture and per-step slice input formation.
// Captures operands on accept, then presents the low or high nibble pair
// with the carry-in each step needs. Assumes the kept low carry is supplied.
module nibser_oper #(
    parameter int NIB_W = 4,
    localparam int DATA_W = 2 * NIB_W,
    localparam int IN_W   = 2 * NIB_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic [2:0]        op,
    input  logic              sel_hi,
    input  logic              carry_kept,
    output logic [DATA_W-1:0] a_q,
    output logic              cin_q,
    output logic [2:0]        op_q,
    output logic [IN_W-1:0]   slice_in
);
    import nibser_alu_pkg::*;

    logic [DATA_W-1:0] b_q;
    logic [NIB_W-1:0]  na, nb;
    logic              lo_ci, hi_ci, step_ci;

    // Capture operands when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
            op_q  <= '0;
        end else if (accept) begin
            a_q   <= a;
            b_q   <= b;
            cin_q <= cin;
            op_q  <= op;
        end
    end

    // Carry-in choice for each step
    always_comb begin
        case (op_q)
            OP_ADD:  lo_ci = 1'b0;
            OP_SUB:  lo_ci = 1'b1;
            OP_RRC:  lo_ci = a_q[NIB_W];
            default: lo_ci = cin_q;
        endcase
        hi_ci   = (op_q == OP_RRC) ? cin_q : carry_kept;
        step_ci = sel_hi ? hi_ci : lo_ci;
    end

    // Nibble selection and bus packing
    always_comb begin
        na       = sel_hi ? a_q[DATA_W-1:NIB_W] : a_q[NIB_W-1:0];
        nb       = sel_hi ? b_q[DATA_W-1:NIB_W] : b_q[NIB_W-1:0];
        slice_in = {nb, na, step_ci, op_q};
    end
endmodule

// File: rtl/nibser_alu.sv
// Byte ALU built from one nibble slice used in two timed half-phases.
// Keeps the low half-result and carry between steps; final flags come
// from the high step, except the rotate carry which is the kept low carry.
// Assumes synchronous active-low reset.
module nibser_alu #(
    parameter int NIB_W     = 4,
    parameter int PHASE_LEN = 2,
    localparam int DATA_W = 2 * NIB_W,
    localparam int IN_W   = 2 * NIB_W + 4,
    localparam int OUT_W  = NIB_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic [2:0]        op,
    output logic [DATA_W-1:0] result,
    output logic              c_flag,
    output logic              v_flag,
    output logic              done
);
    import nibser_alu_pkg::*;

    logic              idle, accept, sel_hi, store_lo, store_hi;
    logic [DATA_W-1:0] a_q;
    logic              cin_q;
    logic [2:0]        op_q;
    logic [IN_W-1:0]   slice_in;
    logic [OUT_W-1:0]  slice_out;
    logic [NIB_W-1:0]  lo_q;
    logic              carry_q;
    logic [NIB_W-1:0]  s_d;
    logic              s_v, s_c;

    nibser_seq #(.PHASE_LEN(PHASE_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .idle     (idle),
        .accept   (accept),
        .sel_hi   (sel_hi),
        .store_lo (store_lo),
        .store_hi (store_hi)
    );

    nibser_oper #(.NIB_W(NIB_W)) u_oper (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .a          (a),
        .b          (b),
        .cin        (cin),
        .op         (op),
        .sel_hi     (sel_hi),
        .carry_kept (carry_q),
        .a_q        (a_q),
        .cin_q      (cin_q),
        .op_q       (op_q),
        .slice_in   (slice_in)
    );

    nibser_slice #(.NIB_W(NIB_W)) u_slice (
        .in_bus  (slice_in),
        .out_bus (slice_out)
    );

    // Unpack slice outputs
    always_comb {s_d, s_v, s_c} = slice_out;

    // Keep the low half-result and carry at the end of the first half-phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            carry_q <= 1'b0;
        end else if (store_lo) begin
            lo_q    <= s_d;
            carry_q <= s_c;
        end
    end

    // Assemble the byte result and flags at the end of the second half-phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            c_flag <= 1'b0;
            v_flag <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= store_hi;
            if (store_hi) begin
                result <= {s_d, lo_q};
                c_flag <= (op_q == OP_RRC) ? carry_q : s_c;
                v_flag <= is_arith(op_q) ? s_v : 1'b0;
            end
        end
    end
endmodule

// File: rtl/nibser_alu_chk.sv
// Property checker for nibser_alu, attached by bind below.
// Uses a cycle counter in place of long delays for the latency window.
module nibser_alu_chk #(
    parameter int NIB_W     = 4,
    parameter int PHASE_LEN = 2,
    localparam int DATA_W = 2 * NIB_W,
    localparam int LAT    = 2 * PHASE_LEN + 1,
    localparam int CYC_W  = $clog2(LAT + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              idle,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              c_flag,
    input logic              v_flag,
    input logic [DATA_W-1:0] a_q,
    input logic              cin_q,
    input logic [2:0]        op_q
);
    logic [CYC_W-1:0] cyc;

    // Count cycles since the last accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)                 cyc <= '0;
        else if (start && idle)     cyc <= CYC_W'(1);
        else if (cyc != '0 && done) cyc <= '0;
        else if (cyc != '0)         cyc <= cyc + 1'b1;
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == CYC_W'(LAT)));

    a_r3_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !idle) |=> ($stable(a_q) && $stable(op_q) && $stable(cin_q)));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({result, c_flag, v_flag}));

    a_r9_logic_no_v: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q[2]) |-> !v_flag);

    a_r10_rrc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 3'd5) |-> (c_flag == a_q[0] && result[DATA_W-1] == cin_q));
endmodule

bind nibser_alu nibser_alu_chk #(.NIB_W(NIB_W), .PHASE_LEN(PHASE_LEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .idle   (idle),
    .done   (done),
    .result (result),
    .c_flag (c_flag),
    .v_flag (v_flag),
    .a_q    (a_q),
    .cin_q  (cin_q),
    .op_q   (op_q)
);

// File: tb/nibser_alu_tb.sv
`timescale 1ns/1ps
module nibser_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic       cin = 1'b0;
    logic [2:0] op = '0;
    logic [7:0] result;
    logic       c_flag, v_flag, done;

    int checks = 0;
    int fails  = 0;

    nibser_alu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b), .cin(cin),
        .op(op), .result(result), .c_flag(c_flag), .v_flag(v_flag), .done(done)
    );

    always #2.5 clk = ~clk;

    // Record one check; print a FAIL line on mismatch
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent reference: returns {result, c, v}
    function automatic logic [9:0] model(input logic [2:0] o, input logic [7:0] x,
                                         input logic [7:0] y, input logic ci);
        int s;
        logic [7:0] r;
        logic c, v;
        v = 1'b0;
        case (o)
            3'd0, 3'd1: begin
                s = int'(x) + int'(y) + ((o == 3'd1) ? int'(ci) : 0);
                r = s[7:0]; c = s[8];
                v = (x[7] == y[7]) && (r[7] != x[7]);
            end
            3'd2, 3'd3: begin
                s = int'(x) + int'(8'hFF - y) + ((o == 3'd2) ? 1 : int'(ci));
                r = s[7:0]; c = s[8];
                v = (x[7] != y[7]) && (r[7] != x[7]);
            end
            3'd4: begin r = ~(x & y); c = ci; end
            3'd5: begin r = {ci, x[7:1]}; c = x[0]; end
            default: begin r = x; c = ci; end
        endcase
        return {r, c, v};
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R9";
            3'd5: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Issue one operation at the current falling edge and check it; returns at the done edge
    task automatic run_op(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                          input logic ci);
        logic [9:0] e;
        int early;
        e = model(o, x, y, ci);
        op = o; a = x; b = y; cin = ci; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early = 0;
        for (int k = 0; k < 3; k++) begin
            if (done) early++;
            @(negedge clk);
        end
        if (done) early++;
        @(negedge clk);
        chk("R2 no early done", early, 0);
        chk("R2 done pulse", done, 1);
        chk(req_of(o), result, e[9:2]);
        chk({req_of(o), " carry"}, c_flag, e[1]);
        chk((o[2] ? {req_of(o), " overflow"} : "R8 overflow"), v_flag, e[0]);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {result, c_flag, v_flag, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {result, c_flag, v_flag, done}, 0);
    endtask

    // R4..R11 corner operands across every code, issued back to back (R13)
    task automatic t_corners();
        logic [7:0] cv [8];
        cv = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h0F, 8'hF0, 8'h01, 8'h10};
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j += 3)
                    run_op(3'(o), cv[i], cv[j], 1'(i + j));
    endtask

    // Random operands for every code, back to back (R13)
    task automatic t_random();
        for (int n = 0; n < 400; n++)
            run_op(3'($urandom_range(7)), 8'($urandom), 8'($urandom), 1'($urandom));
    endtask

    // R12: outputs hold and done drops while idle after a result
    task automatic t_hold();
        logic [9:0] snap;
        run_op(3'd0, 8'h0F, 8'h01, 1'b1);
        chk("R4 low carry into high nibble", result, 8'h10);
        snap = {result, c_flag, v_flag};
        a = 8'h55; b = 8'hAA; op = 3'd4; cin = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R12 hold", {result, c_flag, v_flag}, snap);
            chk("R2 done low while idle", done, 0);
        end
    endtask

    // R3: a mid-operation start with other operands is ignored
    task automatic t_busy();
        int extra;
        op = 3'd1; a = 8'hFF; b = 8'h00; cin = 1'b1; start = 1'b1;
        @(negedge clk);
        a = 8'h12; b = 8'h34; op = 3'd3; cin = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 done at original time", done, 1);
        chk("R3 first operands kept", {result, c_flag, v_flag}, {8'h00, 1'b1, 1'b0});
        extra = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R3 no second done", extra, 0);
    endtask

    // R8 directed overflow boundaries
    task automatic t_overflow();
        run_op(3'd0, 8'h7F, 8'h01, 1'b0);
        chk("R8 add pos overflow", v_flag, 1);
        run_op(3'd0, 8'h80, 8'hFF, 1'b0);
        chk("R8 add neg overflow", v_flag, 1);
        run_op(3'd2, 8'h80, 8'h01, 1'b0);
        chk("R8 sub overflow", v_flag, 1);
        run_op(3'd2, 8'h7F, 8'hFF, 1'b0);
        chk("R8 sub overflow other sign", v_flag, 1);
        run_op(3'd5, 8'h11, 8'h00, 1'b0);
        chk("R10 rotate middle bit", result, 8'h08);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(5ns * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_hold();
        t_busy();
        t_overflow();
        t_corners();
        t_random();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule